// File: doc/BRIEF.md
# ADC Power-Up and Calibration Sequencer

This block is the master-side controller that takes a serially attached sigma-delta converter from an unknown state to a calibrated, idle state. After a start request it sends a run of all-ones bytes that clears the converter's serial port, holds off for a settling interval, reads back the device identifier and compares it with the expected value. It then loads the operating-mode, configuration and excitation-current registers.

Once the registers are loaded, the block walks an internal calibration schedule over the three differential inputs. For each input it runs an offset (zero-scale) pass and then a gain (full-scale) pass. After each pass it waits for the converter's active-low ready line, and a timeout guards that wait. The block does not shift bits itself. It hands one byte at a time to an external serial engine through a start/done handshake and reads the returned byte on completion. The end result is a done flag, or an error flag if the identifier does not match or the ready line never falls.

Top module: `adc_bringup_seq`

## Requirements
- R1: After reset `done_o`, `error_o` and `busy_o` are low and no transfer is started until `start_i` is sampled high.
- R2: The first four transfers of every run each send 0xFF.
- R3: After the fourth 0xFF transfer completes, no transfer starts for at least `WAIT_CYCLES` clock cycles.
- R4: The identifier read sends 0x60 (read flag in bit 6, address 4 in bits 5:3) and then 0x00. Only bits 3:0 of the byte returned on that second transfer are compared with `DEV_ID`, so bits 7:4 have no effect.
- R5: On an identifier mismatch the block raises `error_o`, keeps `done_o` low, returns to idle and starts no further transfer.
- R6: The mode load sends 0x08 (address 1), then 0x40 (operation code 2 in bits 15:13) and 0x01 (rate code 1 in bits 3:0).
- R7: The configuration load sends 0x10 (address 2) and then `CONF_BASE` with bits 3:0 replaced by the channel number, high byte first. The current-source load sends 0x28 (address 5) and then a byte holding `EXC_CODE` in bits 1:0 and `DIR_CODE` in bits 3:2.
- R8: The calibration schedule has six steps: channel 0 offset, channel 0 gain, then the same two steps for channel 1 and for channel 2. Each step is a configuration load for that channel, followed by a mode load with high byte {op,5'b0} (op 4 for offset, 5 for gain) and low byte 0x01. A full run is 50 transfers.
- R9: After the mode load of a calibration step, no transfer starts while `rdy_n_i` is high.
- R10: If `rdy_n_i` stays high for `TIMEOUT_CYCLES` cycles after a calibration step, the block raises `error_o` and stops. It does not raise the error earlier.
- R11: `done_o` rises when the ready line falls after the last calibration step. A new `start_i` in idle clears `done_o` and `error_o` on the next clock and repeats the whole run. `done_o` and `error_o` are never high together and hold until that new start.
- R12: `xfer_start_o` is a single-cycle pulse and never rises while an earlier transfer is still waiting for `xfer_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a bring-up run (sampled in idle) |
| rdy_n_i | input | 1 | Converter ready, active low |
| xfer_start_o | output | 1 | One-cycle request to the serial engine |
| xfer_tx_o | output | 8 | Byte to send, valid with `xfer_start_o` |
| xfer_done_i | input | 1 | One-cycle completion from the serial engine |
| xfer_rx_i | input | 8 | Byte received, valid with `xfer_done_i` |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last run completed successfully |
| error_o | output | 1 | Last run stopped on ID mismatch or ready timeout |

## Verification
A transfer request appears one cycle after the start request. It also appears one cycle after the `xfer_done_i` that ends the previous byte of a frame. The bench's serial-engine model therefore records every request on the falling edge where it is first visible and compares it at once with the next byte of an independently built expected list. Bytes that follow the reset frame arrive `WAIT_CYCLES`+1 cycles after its last completion, and the bench checks that gap against the lower bound. After a calibration step, the next byte or `done_o` follows the ready fall by two edges, and a timeout `error_o` follows the last step's completion by `TIMEOUT_CYCLES`+1 cycles. Both are measured in cycles recorded by the model. The flag clear is checked on the first falling edge after the start request is taken.

// File: rtl/adc_bringup_pkg.sv
// Shared types and command encoding for the converter bring-up sequencer.
// Assumes a command byte of {0, read, addr[2:0], 000}.
package adc_bringup_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_XFER,
        S_SETTLE,
        S_CAL_WAIT
    } seq_state_t;

    localparam logic [2:0] ADDR_MODE = 3'd1;
    localparam logic [2:0] ADDR_CONF = 3'd2;
    localparam logic [2:0] ADDR_ID   = 3'd4;
    localparam logic [2:0] ADDR_IO   = 3'd5;

    localparam logic [2:0] OP_IDLE     = 3'd2;
    localparam logic [2:0] OP_CAL_ZERO = 3'd4;
    localparam logic [2:0] OP_CAL_FULL = 3'd5;
    localparam logic [3:0] RATE_CODE   = 4'd1;

    // Number of frames ahead of the calibration schedule.
    localparam int unsigned PRE_FRAMES = 5;

    function automatic logic [7:0] cmd_byte(input logic [2:0] addr, input logic rd);
        return {1'b0, rd, addr, 3'b000};
    endfunction

endpackage

// File: rtl/adc_bringup_frame_rom.sv
// Computes the byte to send for (frame, byte index) of the bring-up script,
// plus frame-kind flags. Purely combinational.
// Assumes frames are: reset, ID read, mode load, conf load, IO load, then
// pairs of (conf load, calibration mode load) per calibration step.
module adc_bringup_frame_rom
    import adc_bringup_pkg::*;
#(
    parameter int unsigned FRAME_W   = 5,
    parameter logic [15:0] CONF_BASE = 16'h0010,
    parameter logic [7:0]  IO_BYTE   = 8'h00
) (
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [1:0]         idx_i,
    output logic [7:0]         byte_o,
    output logic               last_o,
    output logic               is_reset_o,
    output logic               is_id_o,
    output logic               is_cal_o
);

    logic [FRAME_W-1:0] rel;
    logic [3:0]         chan;
    logic [15:0]        conf_word;
    logic [15:0]        mode_word;

    // Byte and flag selection for the current frame position.
    always_comb begin
        rel        = frame_i - FRAME_W'(PRE_FRAMES);
        chan       = 4'((rel >> 2) & FRAME_W'(15));
        conf_word  = {CONF_BASE[15:4], chan};
        mode_word  = {rel[1] ? OP_CAL_FULL : OP_CAL_ZERO, 9'd0, RATE_CODE};
        byte_o     = 8'h00;
        last_o     = 1'b0;
        is_reset_o = 1'b0;
        is_id_o    = 1'b0;
        is_cal_o   = 1'b0;
        if (frame_i == FRAME_W'(0)) begin
            is_reset_o = 1'b1;
            byte_o     = 8'hFF;
            last_o     = (idx_i == 2'd3);
        end else if (frame_i == FRAME_W'(1)) begin
            is_id_o = 1'b1;
            byte_o  = (idx_i == 2'd0) ? cmd_byte(ADDR_ID, 1'b1) : 8'h00;
            last_o  = (idx_i == 2'd1);
        end else if (frame_i == FRAME_W'(4)) begin
            byte_o = (idx_i == 2'd0) ? cmd_byte(ADDR_IO, 1'b0) : IO_BYTE;
            last_o = (idx_i == 2'd1);
        end else begin
            if (frame_i == FRAME_W'(2)) begin
                mode_word = {OP_IDLE, 9'd0, RATE_CODE};
            end
            if (frame_i == FRAME_W'(3)) begin
                conf_word = {CONF_BASE[15:4], 4'd0};
            end
            if (frame_i == FRAME_W'(2) || (frame_i >= FRAME_W'(PRE_FRAMES) && rel[0])) begin
                is_cal_o = (frame_i != FRAME_W'(2));
                case (idx_i)
                    2'd0:    byte_o = cmd_byte(ADDR_MODE, 1'b0);
                    2'd1:    byte_o = mode_word[15:8];
                    default: byte_o = mode_word[7:0];
                endcase
            end else begin
                case (idx_i)
                    2'd0:    byte_o = cmd_byte(ADDR_CONF, 1'b0);
                    2'd1:    byte_o = conf_word[15:8];
                    default: byte_o = conf_word[7:0];
                endcase
            end
            last_o = (idx_i == 2'd2);
        end
    end

endmodule

// File: rtl/adc_bringup_timer.sv
// Loadable down-counter used for both the settle delay and the ready timeout.
// Assumes load has priority; the counter parks at zero.
module adc_bringup_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_bringup_seq.sv
// Bring-up sequencer for a serially attached sigma-delta converter: reset run,
// settle delay, ID check, register loads and a ready-gated calibration
// schedule. Assumes an external byte engine with one-cycle start/done pulses
// and an active-low ready line from the converter.
module adc_bringup_seq
    import adc_bringup_pkg::*;
#(
    parameter logic [3:0]  DEV_ID         = 4'hB,
    parameter int unsigned WAIT_CYCLES    = 25000,
    parameter int unsigned TIMEOUT_CYCLES = 1000000,
    parameter logic [15:0] CONF_BASE      = 16'h0010,
    parameter logic [1:0]  EXC_CODE       = 2'd1,
    parameter logic [1:0]  DIR_CODE       = 2'd0,
    parameter int unsigned CAL_CHANNELS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       rdy_n_i,
    output logic       xfer_start_o,
    output logic [7:0] xfer_tx_o,
    input  logic       xfer_done_i,
    input  logic [7:0] xfer_rx_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       error_o
);

    localparam int unsigned NUM_FRAMES = PRE_FRAMES + 4 * CAL_CHANNELS;
    localparam int unsigned FRAME_W    = $clog2(NUM_FRAMES);
    localparam int unsigned TMR_MAX    = (WAIT_CYCLES > TIMEOUT_CYCLES) ? WAIT_CYCLES : TIMEOUT_CYCLES;
    localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);
    localparam logic [7:0] IO_BYTE = {4'd0, DIR_CODE, EXC_CODE};

    seq_state_t         state_q;
    logic [FRAME_W-1:0] frame_q;
    logic [1:0]         idx_q;
    logic               done_q;
    logic               error_q;

    logic               frm_last;
    logic               frm_reset;
    logic               frm_id;
    logic               frm_cal;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic               frame_end;
    logic               id_bad;

    adc_bringup_frame_rom #(
        .FRAME_W   (FRAME_W),
        .CONF_BASE (CONF_BASE),
        .IO_BYTE   (IO_BYTE)
    ) u_rom (
        .frame_i    (frame_q),
        .idx_i      (idx_q),
        .byte_o     (xfer_tx_o),
        .last_o     (frm_last),
        .is_reset_o (frm_reset),
        .is_id_o    (frm_id),
        .is_cal_o   (frm_cal)
    );

    adc_bringup_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // End-of-frame, ID comparison and timer load decode.
    always_comb begin
        frame_end = (state_q == S_XFER) && xfer_done_i && frm_last;
        id_bad    = ((xfer_rx_i & 8'h0F) != {4'd0, DEV_ID});
        tmr_load  = frame_end && (frm_reset || frm_cal);
        tmr_val   = frm_reset ? TMR_W'(WAIT_CYCLES - 1) : TMR_W'(TIMEOUT_CYCLES - 1);
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            frame_q <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
            error_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        frame_q <= '0;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                        error_q <= 1'b0;
                        state_q <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    state_q <= S_XFER;
                end
                S_XFER: begin
                    if (xfer_done_i) begin
                        if (!frm_last) begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= S_ISSUE;
                        end else begin
                            idx_q <= '0;
                            if (frm_id && id_bad) begin
                                error_q <= 1'b1;
                                state_q <= S_IDLE;
                            end else if (frm_reset) begin
                                state_q <= S_SETTLE;
                            end else if (frm_cal) begin
                                state_q <= S_CAL_WAIT;
                            end else begin
                                frame_q <= frame_q + 1'b1;
                                state_q <= S_ISSUE;
                            end
                        end
                    end
                end
                S_SETTLE: begin
                    if (tmr_zero) begin
                        frame_q <= frame_q + 1'b1;
                        state_q <= S_ISSUE;
                    end
                end
                S_CAL_WAIT: begin
                    if (!rdy_n_i) begin
                        if (frame_q == LAST_FRAME) begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            frame_q <= frame_q + 1'b1;
                            state_q <= S_ISSUE;
                        end
                    end else if (tmr_zero) begin
                        error_q <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign xfer_start_o = (state_q == S_ISSUE);
    assign busy_o       = (state_q != S_IDLE);
    assign done_o       = done_q;
    assign error_o      = error_q;

endmodule

// File: rtl/adc_bringup_chk.sv
// Protocol and flag checker for adc_bringup_seq, attached by bind.
// Assumes synchronous active-low reset on the same clock.
module adc_bringup_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic xfer_start_o,
    input logic xfer_done_i,
    input logic busy_o,
    input logic done_o,
    input logic error_o
);

    logic pending_q;

    // Tracks a transfer request that has not yet been acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (xfer_start_o) begin
            pending_q <= 1'b1;
        end else if (xfer_done_i) begin
            pending_q <= 1'b0;
        end
    end

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |=> !xfer_start_o);

    a_r12_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> !pending_q);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !xfer_start_o);

    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    a_r5_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);

    a_r11_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

bind adc_bringup_seq adc_bringup_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .xfer_start_o (xfer_start_o),
    .xfer_done_i  (xfer_done_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o)
);

// File: tb/adc_bringup_seq_tb.sv
// Bench: behavioural serial-engine and converter model, expected byte list
// built from the requirements, compared on every falling edge.
module adc_bringup_seq_tb;

    localparam logic [3:0]  P_ID      = 4'hB;
    localparam int          P_WAIT    = 40;
    localparam int          P_TMO     = 200;
    localparam logic [15:0] P_CONF    = 16'h1015;
    localparam logic [1:0]  P_EXC     = 2'd2;
    localparam logic [1:0]  P_DIR     = 2'd1;
    localparam int          LAT       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       rdy_n_i = 1'b0;
    logic       xfer_start_o;
    logic [7:0] xfer_tx_o;
    logic       xfer_done_i = 1'b0;
    logic [7:0] xfer_rx_i = 8'h00;
    logic       busy_o;
    logic       done_o;
    logic       error_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int byte_no = 0;
    int run_base = 0;
    int lat_cnt = 0;
    int rdy_cnt = 0;
    int cal_delay = 30;
    int reset_done_cyc = 0;
    int calend_cyc = 0;
    logic [7:0] id_resp = 8'h0B;
    logic abort_cal = 1'b0;
    logic cur_calend = 1'b0;
    logic cur_reset_end = 1'b0;
    logic [7:0] cur_rx = 8'h00;
    logic prev_start = 1'b0;
    logic finished = 1'b0;
    logic [7:0] exp_q[$];
    logic       calend_q[$];

    always #10 clk = ~clk;

    adc_bringup_seq #(
        .DEV_ID         (P_ID),
        .WAIT_CYCLES    (P_WAIT),
        .TIMEOUT_CYCLES (P_TMO),
        .CONF_BASE      (P_CONF),
        .EXC_CODE       (P_EXC),
        .DIR_CODE       (P_DIR),
        .CAL_CHANNELS   (3)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .rdy_n_i      (rdy_n_i),
        .xfer_start_o (xfer_start_o),
        .xfer_tx_o    (xfer_tx_o),
        .xfer_done_i  (xfer_done_i),
        .xfer_rx_i    (xfer_rx_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .error_o      (error_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic string req_of(input int i);
        if (i < 4)  return "R2";
        if (i < 6)  return "R4";
        if (i < 9)  return "R6";
        if (i < 14) return "R7";
        return "R8";
    endfunction

    task automatic push(input logic [7:0] b, input logic endcal);
        exp_q.push_back(b);
        calend_q.push_back(endcal);
    endtask

    // Expected script built from the requirement text.
    task automatic build_expected();
        logic [15:0] cw;
        for (int i = 0; i < 4; i++) push(8'hFF, 1'b0);
        push(8'h60, 1'b0); push(8'h00, 1'b0);
        push(8'h08, 1'b0); push(8'h40, 1'b0); push(8'h01, 1'b0);
        cw = {P_CONF[15:4], 4'd0};
        push(8'h10, 1'b0); push(cw[15:8], 1'b0); push(cw[7:0], 1'b0);
        push(8'h28, 1'b0); push({4'd0, P_DIR, P_EXC}, 1'b0);
        for (int ch = 0; ch < 3; ch++) begin
            for (int s = 0; s < 2; s++) begin
                cw = {P_CONF[15:4], 4'(ch)};
                push(8'h10, 1'b0); push(cw[15:8], 1'b0); push(cw[7:0], 1'b0);
                push(8'h08, 1'b0); push({3'(4 + s), 5'd0}, 1'b0); push(8'h01, 1'b1);
            end
        end
    endtask

    // Serial engine and converter model, evaluated on every falling edge.
    always @(negedge clk) begin
        int idx;
        cyc++;
        xfer_done_i = 1'b0;
        if (abort_cal) begin
            rdy_cnt = 0;
            rdy_n_i = 1'b0;
        end
        if (rdy_n_i && rdy_cnt > 0) begin
            rdy_cnt--;
            if (rdy_cnt == 0) rdy_n_i = 1'b0;
        end
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                xfer_done_i = 1'b1;
                xfer_rx_i   = cur_rx;
                if (cur_calend) begin
                    rdy_n_i    = 1'b1;
                    rdy_cnt    = cal_delay;
                    calend_cyc = cyc;
                end
                if (cur_reset_end) reset_done_cyc = cyc;
            end
        end
        if (xfer_start_o) begin
            idx = byte_no - run_base;
            chk("R12 start while pending or held", int'(prev_start || lat_cnt != 0), 0);
            if (rdy_n_i) chk("R9 transfer while ready high", 1, 0);
            if (idx == 4) begin
                n_chk++;
                if (cyc - reset_done_cyc < P_WAIT) begin
                    n_fail++;
                    $display("FAIL R3: gap %0d expected >= %0d", cyc - reset_done_cyc, P_WAIT);
                end
            end
            if (idx < exp_q.size()) begin
                chk(req_of(idx), int'(xfer_tx_o), int'(exp_q[idx]));
                cur_calend = calend_q[idx];
            end else begin
                chk("R8 extra transfer", idx, exp_q.size() - 1);
                cur_calend = 1'b0;
            end
            cur_reset_end = (idx == 3);
            cur_rx  = (idx == 5) ? id_resp : 8'h00;
            lat_cnt = LAT;
            byte_no++;
        end
        prev_start = xfer_start_o;
    end

    task automatic run_seq(input logic [7:0] idr, input int dly, output int idle_cyc);
        run_base  = byte_no;
        id_resp   = idr;
        cal_delay = dly;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk("R11 flags cleared on start", int'({done_o, error_o}), 0);
        chk("R11 busy after start", int'(busy_o), 1);
        while (busy_o) @(negedge clk);
        idle_cyc = cyc;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        int t_idle;
        build_expected();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset flags", int'({done_o, error_o, busy_o, xfer_start_o}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 no transfer before start", byte_no, 0);
        chk("R1 idle before start", int'(busy_o), 0);

        // Nominal run, exact ID.
        run_seq(8'h0B, 30, t_idle);
        chk("R8 transfer count", byte_no - run_base, 50);
        chk("R11 done after last step", int'(done_o), 1);
        chk("R11 no error", int'(error_o), 0);
        chk("R9 done after ready fall", int'(rdy_n_i), 0);

        // Upper nibble of ID differs, must still pass; short ready delay.
        run_seq(8'h5B, 2, t_idle);
        chk("R4 upper nibble ignored (done)", int'(done_o), 1);
        chk("R4 upper nibble ignored (count)", byte_no - run_base, 50);

        // ID mismatch.
        run_seq(8'h0C, 30, t_idle);
        repeat (20) @(negedge clk);
        chk("R5 error on mismatch", int'(error_o), 1);
        chk("R5 done low on mismatch", int'(done_o), 0);
        chk("R5 no transfer after mismatch", byte_no - run_base, 6);

        // Ready never falls: timeout.
        run_seq(8'h0B, 100000, t_idle);
        chk("R10 error on timeout", int'(error_o), 1);
        chk("R10 stops after first step", byte_no - run_base, 20);
        n_chk++;
        if (t_idle - calend_cyc < P_TMO) begin
            n_fail++;
            $display("FAIL R10: error after %0d cycles expected >= %0d", t_idle - calend_cyc, P_TMO);
        end
        @(negedge clk) abort_cal = 1'b1;
        @(negedge clk) abort_cal = 1'b0;

        // Recovery run after an error.
        run_seq(8'h0B, 10, t_idle);
        chk("R11 rerun after error done", int'(done_o), 1);
        chk("R11 rerun after error count", byte_no - run_base, 50);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

endmodule